// File: doc/BRIEF.md
# Multi-cycle 8-bit toy processor core

`toy8_core` is a small processor core that steps through each instruction in several clock cycles. It has four general-purpose 8-bit registers and a program counter that no instruction can name. It talks to one 8-bit-address, 8-bit-data memory through a single port. Reads from that port are combinational: the read data follows the address in the same cycle. Writes take effect at the next rising clock edge.

Each instruction passes through an opcode fetch, a decode step, an optional fetch of an immediate byte, and an execute step. The execute step may make one memory access. The core runs register copies, loads and stores through a register pointer, and immediate loads. It also runs unconditional jumps to an immediate or to a register value, jumps that depend on one of five flags, and arithmetic and logic operations.

When the core meets an opcode with no defined meaning, it stops and raises `halted`. It stays stopped until reset. Test programs use this as their end marker.

Top module: `toy8_core`

## Requirements
- R1: Reset clears the program counter, all four registers and all flags. The first opcode is fetched from address 0, and `mem_addr` reads 0 while reset is held.
- R2: Opcode byte layout: bits [7:4] give the operation, bits [3:2] name register x and bits [1:0] name register y. Register codes are A=0, B=1, C=2, D=3. Operation codes are: 0 copy, 1 load, 2 store, 3 load-immediate, 4 jump-immediate, 5 conditional jump, 6 jump-register, 7 compare, 8 add, 9 subtract, A and, B or, C not, D shift-right, E increment, F decrement.
- R3: The opcode fetch adds one to the program counter. A one-byte instruction takes 3 cycles and a two-byte instruction takes 4.
- R4: Load-immediate writes x with the byte that follows the opcode, and execution resumes after that byte.
- R5: Load writes x with the memory byte at the address held in y. Store writes x to the address held in y. The memory write strobe rises only during the execute step of a store.
- R6: Copy sets x to y. Jump-register sets the program counter to x.
- R7: Jump-immediate loads the program counter with the immediate byte. A conditional jump uses opcode bits [2:0] to pick a flag: 0 carry, 1 zero, 2 sign, 3 overflow, 4 less. It jumps when that flag is 1 and otherwise continues after its immediate byte.
- R8: Add and subtract write x and update all five flags. Compare updates the flags exactly as subtract would but leaves every register unchanged. Carry is the carry out of an add, or the borrow (x < y unsigned) of a subtract. Overflow is signed overflow. Less is sign XOR overflow.
- R9: And, or, not x and shift-right (x >> y, giving 0 when y ≥ 8) write x. They update zero and sign, and set less equal to sign. Carry and overflow keep their previous values.
- R10: Increment and decrement change x by one and leave all flags unchanged.
- R11: A conditional jump whose condition code is 5, 6 or 7 stops the core. `halted` then stays at 1 and no further memory write occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_addr | output | 8 | Memory address for fetch, immediate read, load or store |
| mem_rdata | input | 8 | Memory read data, valid in the same cycle as `mem_addr` |
| mem_wdata | output | 8 | Memory write data |
| mem_we | output | 1 | Memory write strobe, sampled at the rising edge |
| halted | output | 1 | High once the core has stopped on an undefined opcode |

## Verification
The bench builds the core with its default parameters: 8-bit data, four registers and a reset address of 0. With these settings the whole 256-byte address space is usable, so programs can sit at the bottom of memory while flag and result probes are stored near the top. Every flag is read back by a chain of conditional jumps that each store 0 or 1. One run therefore covers both the taken and the fall-through path of all five flag conditions, along with boundary values such as 0x7F+1, 0xFF+1 and shift amounts of 8 or more.

// File: rtl/toy8_pkg.sv
package toy8_pkg;
    parameter int DATA_W    = 8;
    parameter int NUM_REGS  = 4;
    localparam int SEL_W    = $clog2(NUM_REGS);
    localparam int OPC_W    = 4;
    localparam int COND_W   = 3;

    typedef enum logic [2:0] {
        ST_FETCH, ST_DECODE, ST_IMM, ST_EXEC, ST_HALT
    } fsm_e;

    typedef enum logic [OPC_W-1:0] {
        OP_CPR, OP_LD, OP_ST, OP_LDI, OP_JMPI, OP_JCC, OP_JMP, OP_CMP,
        OP_ADD, OP_SUB, OP_AND, OP_OR, OP_NOT, OP_RSH, OP_INC, OP_DEC
    } op_e;

    typedef struct packed {
        logic l;
        logic o;
        logic s;
        logic z;
        logic c;
    } flags_t;

    typedef struct packed {
        fsm_e                               fsm;
        logic [DATA_W-1:0]                  pc;
        logic [DATA_W-1:0]                  ir;
        logic [DATA_W-1:0]                  imm;
        logic [NUM_REGS-1:0][DATA_W-1:0]    regs;
        flags_t                             flags;
    } core_t;
endpackage

// File: rtl/toy8_decode.sv
module toy8_decode
    import toy8_pkg::*;
(
    input  logic [DATA_W-1:0] ir,
    output op_e               op,
    output logic [SEL_W-1:0]  xsel,
    output logic [SEL_W-1:0]  ysel,
    output logic [COND_W-1:0] cond,
    output logic              two_byte,
    output logic              illegal
);
    localparam int NUM_COND = 5;

    always_comb begin
        op       = op_e'(ir[DATA_W-1 -: OPC_W]);
        xsel     = ir[2*SEL_W-1 -: SEL_W];
        ysel     = ir[SEL_W-1:0];
        cond     = ir[COND_W-1:0];
        two_byte = (op == OP_LDI) || (op == OP_JMPI) || (op == OP_JCC);
        illegal  = (op == OP_JCC) && (32'(cond) >= NUM_COND);
    end
endmodule

// File: rtl/toy8_alu.sv
module toy8_alu
    import toy8_pkg::*;
(
    input  op_e               op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  flags_t            fin,
    output logic [DATA_W-1:0] res,
    output flags_t            fout
);
    localparam int MSB = DATA_W - 1;

    logic [DATA_W:0] sum;
    logic [DATA_W:0] diff;
    logic            arith;

    always_comb begin
        sum   = {1'b0, a} + {1'b0, b};
        diff  = {1'b0, a} - {1'b0, b};
        fout  = fin;
        arith = 1'b0;
        res   = a;
        unique case (op)
            OP_ADD: begin
                res    = sum[MSB:0];
                fout.c = sum[DATA_W];
                fout.o = (a[MSB] == b[MSB]) && (res[MSB] != a[MSB]);
                arith  = 1'b1;
            end
            OP_SUB, OP_CMP: begin
                res    = diff[MSB:0];
                fout.c = diff[DATA_W];
                fout.o = (a[MSB] != b[MSB]) && (res[MSB] != a[MSB]);
                arith  = 1'b1;
            end
            OP_AND: res = a & b;
            OP_OR:  res = a | b;
            OP_NOT: res = ~a;
            OP_RSH: res = (32'(b) >= DATA_W) ? '0 : (a >> b);
            OP_INC: res = a + DATA_W'(1);
            OP_DEC: res = a - DATA_W'(1);
            default: res = a;
        endcase
        if (op != OP_INC && op != OP_DEC) begin
            fout.z = (res == '0);
            fout.s = res[MSB];
            fout.l = arith ? (res[MSB] ^ fout.o) : res[MSB];
        end
    end
endmodule

// File: rtl/toy8_core.sv
module toy8_core
    import toy8_pkg::*;
#(
    parameter int RESET_PC = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [DATA_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_we,
    output logic              halted
);
    core_t state_q, state_d;

    op_e               dec_op;
    logic [SEL_W-1:0]  xsel, ysel;
    logic [COND_W-1:0] cond;
    logic              two_byte, illegal;
    logic [DATA_W-1:0] alu_res;
    flags_t            alu_flags;
    logic              cond_true;

    toy8_decode u_dec (
        .ir       (state_q.ir),
        .op       (dec_op),
        .xsel     (xsel),
        .ysel     (ysel),
        .cond     (cond),
        .two_byte (two_byte),
        .illegal  (illegal)
    );

    toy8_alu u_alu (
        .op   (dec_op),
        .a    (state_q.regs[xsel]),
        .b    (state_q.regs[ysel]),
        .fin  (state_q.flags),
        .res  (alu_res),
        .fout (alu_flags)
    );

    always_comb begin
        case (cond)
            3'd0:    cond_true = state_q.flags.c;
            3'd1:    cond_true = state_q.flags.z;
            3'd2:    cond_true = state_q.flags.s;
            3'd3:    cond_true = state_q.flags.o;
            default: cond_true = state_q.flags.l;
        endcase
    end

    always_comb begin
        state_d   = state_q;
        mem_addr  = state_q.pc;
        mem_wdata = state_q.regs[xsel];
        mem_we    = 1'b0;
        unique case (state_q.fsm)
            ST_FETCH: begin
                state_d.ir  = mem_rdata;
                state_d.pc  = state_q.pc + DATA_W'(1);
                state_d.fsm = ST_DECODE;
            end
            ST_DECODE: begin
                if (illegal)       state_d.fsm = ST_HALT;
                else if (two_byte) state_d.fsm = ST_IMM;
                else               state_d.fsm = ST_EXEC;
            end
            ST_IMM: begin
                state_d.imm = mem_rdata;
                state_d.fsm = ST_EXEC;
            end
            ST_EXEC: begin
                state_d.fsm = ST_FETCH;
                unique case (dec_op)
                    OP_CPR: state_d.regs[xsel] = state_q.regs[ysel];
                    OP_LD: begin
                        mem_addr                = state_q.regs[ysel];
                        state_d.regs[xsel]      = mem_rdata;
                    end
                    OP_ST: begin
                        mem_addr = state_q.regs[ysel];
                        mem_we   = 1'b1;
                    end
                    OP_LDI: begin
                        state_d.regs[xsel] = state_q.imm;
                        state_d.pc         = state_q.pc + DATA_W'(1);
                    end
                    OP_JMPI: state_d.pc = state_q.imm;
                    OP_JCC:  state_d.pc = cond_true ? state_q.imm
                                                    : state_q.pc + DATA_W'(1);
                    OP_JMP:  state_d.pc = state_q.regs[xsel];
                    OP_CMP:  state_d.flags = alu_flags;
                    default: begin
                        state_d.regs[xsel] = alu_res;
                        state_d.flags      = alu_flags;
                    end
                endcase
            end
            default: state_d.fsm = ST_HALT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= '0;
            state_q.fsm <= ST_FETCH;
            state_q.pc  <= DATA_W'(RESET_PC);
        end else begin
            state_q <= state_d;
        end
    end

    assign halted = (state_q.fsm == ST_HALT);
endmodule

// File: rtl/toy8_core_chk.sv
module toy8_core_chk
    import toy8_pkg::*;
(
    input logic                            clk,
    input logic                            rst_n,
    input fsm_e                            fsm,
    input logic [DATA_W-1:0]               pc,
    input op_e                             op,
    input flags_t                          flags,
    input logic [NUM_REGS-1:0][DATA_W-1:0] regs,
    input logic                            mem_we,
    input logic                            halted
);
    assert_fetch_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm == ST_FETCH) |=> (pc == $past(pc) + DATA_W'(1)));

    assert_write_only_store_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (fsm == ST_EXEC && op == OP_ST));

    assert_cmp_keeps_regs_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm == ST_EXEC && op == OP_CMP) |=> $stable(regs));

    assert_incdec_keeps_flags_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm == ST_EXEC && (op == OP_INC || op == OP_DEC)) |=> $stable(flags));

    assert_halt_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);

    assert_halt_no_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !mem_we);
endmodule

bind toy8_core toy8_core_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .fsm    (state_q.fsm),
    .pc     (state_q.pc),
    .op     (dec_op),
    .flags  (state_q.flags),
    .regs   (state_q.regs),
    .mem_we (mem_we),
    .halted (halted)
);

// File: tb/test_toy8_core.sv
`timescale 1ns/1ps
module test_toy8_core;
    localparam logic [3:0] K_CPR = 4'h0, K_LD = 4'h1, K_ST = 4'h2, K_LDI = 4'h3,
                           K_JMPI = 4'h4, K_JCC = 4'h5, K_JMP = 4'h6, K_CMP = 4'h7,
                           K_ADD = 4'h8, K_SUB = 4'h9, K_AND = 4'hA, K_OR = 4'hB,
                           K_NOT = 4'hC, K_RSH = 4'hD, K_INC = 4'hE, K_DEC = 4'hF;
    localparam int RA = 0, RB = 1, RC = 2, RD = 3;
    localparam logic [7:0] STOP = 8'h57;   // cond code 7: undefined

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] mem_addr, mem_rdata, mem_wdata;
    logic       mem_we, halted;
    logic [7:0] ram [0:255];
    int         cur;
    int         n_checks = 0;
    int         n_err = 0;
    int         we_after_halt = 0;

    always #2 clk = ~clk;

    toy8_core i_toy8_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .mem_addr  (mem_addr),
        .mem_rdata (mem_rdata),
        .mem_wdata (mem_wdata),
        .mem_we    (mem_we),
        .halted    (halted)
    );

    assign mem_rdata = ram[mem_addr];
    always @(posedge clk) if (mem_we) ram[mem_addr] <= mem_wdata;
    always @(negedge clk) if (rst_n && halted && mem_we) we_after_halt++;

    function automatic logic [7:0] enc(input logic [3:0] op, input int x, input int y);
        return {op, 2'(x), 2'(y)};
    endfunction

    // returns {L,O,S,Z,C, result}
    function automatic logic [12:0] model(input logic [3:0] op, input logic [7:0] a,
                                          input logic [7:0] b, input logic [4:0] fin);
        logic [8:0] t;
        logic [7:0] r;
        logic c, o, s, z, l, ar;
        c = fin[0]; o = fin[3]; ar = 1'b0; r = a;
        case (op)
            K_ADD: begin t = {1'b0, a} + {1'b0, b}; r = t[7:0]; c = t[8];
                         o = (a[7] == b[7]) && (r[7] != a[7]); ar = 1'b1; end
            K_SUB, K_CMP: begin r = a - b; c = (a < b);
                         o = (a[7] != b[7]) && (r[7] != a[7]); ar = 1'b1; end
            K_AND: r = a & b;
            K_OR:  r = a | b;
            K_NOT: r = ~a;
            K_RSH: r = (b > 8'd7) ? 8'h00 : (a >> b);
            K_INC: return {fin, a + 8'd1};
            K_DEC: return {fin, a - 8'd1};
            default: r = a;
        endcase
        z = (r == 8'h00); s = r[7]; l = ar ? (s ^ o) : s;
        return {l, o, s, z, c, r};
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic em(input logic [7:0] b);
        ram[cur[7:0]] = b;
        cur++;
    endtask

    task automatic hold_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        for (int i = 0; i < 256; i++) ram[i] = 8'h00;
        cur = 0;
        we_after_halt = 0;
    endtask

    task automatic run(output int cycles);
        rst_n = 1'b1;
        cycles = 0;
        while (!halted && cycles < 5000) begin
            @(negedge clk);
            cycles++;
        end
    endtask

    // stores 1 at (C) if flag f set, else 0, then bumps C; uses D
    task automatic probe(input int f);
        int s;
        s = cur;
        em({K_JCC, 1'b0, 3'(f)}); em(8'(s + 6));
        em(enc(K_LDI, RD, 0));    em(8'h00);
        em(enc(K_JMPI, 0, 0));    em(8'(s + 8));
        em(enc(K_LDI, RD, 0));    em(8'h01);
        em(enc(K_ST, RD, RC));
        em(enc(K_INC, RC, 0));
    endtask

    task automatic test_reset();
        int cyc;
        hold_reset();
        check(mem_addr == 8'h00, "R1", "addr in reset", mem_addr, 0);
        check(halted == 1'b0, "R1", "halted in reset", halted, 0);
        ram[8'hF0] = 8'hAA; ram[8'hF1] = 8'hAA; ram[8'hF2] = 8'hAA;
        em(enc(K_LDI, RC, 0)); em(8'hF0);
        em(enc(K_ST, RA, RC)); em(enc(K_INC, RC, 0));
        em(enc(K_ST, RB, RC)); em(enc(K_INC, RC, 0));
        em(enc(K_ST, RD, RC)); em(STOP);
        run(cyc);
        check(ram[8'hF0] == 8'h00, "R1", "reg A after reset", ram[8'hF0], 0);
        check(ram[8'hF1] == 8'h00, "R1", "reg B after reset", ram[8'hF1], 0);
        check(ram[8'hF2] == 8'h00, "R1", "reg D after reset", ram[8'hF2], 0);
    endtask

    task automatic test_timing();
        int cyc;
        hold_reset();
        em(enc(K_CPR, RA, RA)); em(STOP);
        run(cyc);
        check(cyc == 5, "R3", "cycles one-byte+stop", cyc, 5);
        hold_reset();
        em(enc(K_LDI, RA, 0)); em(8'h12); em(STOP);
        run(cyc);
        check(cyc == 6, "R3", "cycles two-byte+stop", cyc, 6);
    endtask

    task automatic test_data();
        int cyc;
        hold_reset();
        em(enc(K_LDI, RA, 0)); em(8'h3C);      // R4
        em(enc(K_LDI, RB, 0)); em(8'h80);
        em(enc(K_ST, RA, RB));                 // R5 store A at (B)
        em(enc(K_LD, RC, RB));                 // R5 load C from (B)
        em(enc(K_LDI, RD, 0)); em(8'h81);
        em(enc(K_ST, RC, RD));
        em(enc(K_LDI, RA, 0)); em(8'hC3);
        em(enc(K_CPR, RB, RA));                // R6 copy
        em(enc(K_LDI, RD, 0)); em(8'h82);
        em(enc(K_ST, RB, RD));
        em(STOP);
        run(cyc);
        check(ram[8'h80] == 8'h3C, "R4", "ldi then store", ram[8'h80], 8'h3C);
        check(ram[8'h81] == 8'h3C, "R5", "load via pointer", ram[8'h81], 8'h3C);
        check(ram[8'h82] == 8'hC3, "R6", "copy register", ram[8'h82], 8'hC3);
        check(ram[8'h83] == 8'h00, "R2", "no stray write", ram[8'h83], 0);
    endtask

    task automatic test_jumps();
        int cyc;
        hold_reset();
        em(enc(K_LDI, RA, 0)); em(8'h55);      // 0
        em(enc(K_LDI, RC, 0)); em(8'h90);      // 2
        em(enc(K_JMPI, 0, 0)); em(8'h07);      // 4
        em(enc(K_ST, RA, RC));                 // 6 skipped
        em(enc(K_LDI, RB, 0)); em(8'h0B);      // 7
        em(enc(K_JMP, RB, 0));                 // 9
        em(enc(K_ST, RA, RC));                 // 10 skipped
        em(enc(K_INC, RC, 0));                 // 11
        em(enc(K_ST, RA, RC));                 // 12
        em(STOP);
        run(cyc);
        check(ram[8'h90] == 8'h00, "R7", "jmpi skips store", ram[8'h90], 0);
        check(ram[8'h91] == 8'h55, "R6", "jmp reg lands", ram[8'h91], 8'h55);
    endtask

    task automatic alu_case(input string req, input logic [3:0] op,
                            input logic [7:0] va, input logic [7:0] vb);
        int cyc;
        logic [12:0] pre, m;
        logic [7:0] exp_a;
        hold_reset();
        em(enc(K_LDI, RA, 0)); em(8'hFF);
        em(enc(K_LDI, RB, 0)); em(8'h01);
        em(enc(K_ADD, RA, RB));                // sets C=1, Z=1
        pre = model(K_ADD, 8'hFF, 8'h01, 5'b0);
        em(enc(K_LDI, RA, 0)); em(va);
        em(enc(K_LDI, RB, 0)); em(vb);
        em(enc(K_LDI, RC, 0)); em(8'hE0);
        em(enc(op, RA, RB));
        for (int f = 0; f < 5; f++) probe(f);
        em(enc(K_LDI, RC, 0)); em(8'hF0);
        em(enc(K_ST, RA, RC));
        em(STOP);
        run(cyc);
        m = model(op, va, vb, pre[12:8]);
        exp_a = (op == K_CMP) ? va : m[7:0];
        check(ram[8'hF0] == exp_a, req, "result", ram[8'hF0], exp_a);
        for (int f = 0; f < 5; f++)
            check(ram[8'hE0 + f] == {7'b0, m[8 + f]}, req, $sformatf("flag %0d (R7 probe)", f),
                  ram[8'hE0 + f], m[8 + f]);
    endtask

    task automatic incdec_case(input logic [3:0] op, input logic [7:0] va);
        int cyc;
        logic [12:0] pre;
        logic [7:0]  exp_a;
        hold_reset();
        em(enc(K_LDI, RA, 0)); em(va);
        em(enc(K_LDI, RB, 0)); em(8'h00);
        em(enc(K_ADD, RA, RB));
        pre = model(K_ADD, va, 8'h00, 5'b0);
        em(enc(op, RA, 0));
        em(enc(K_LDI, RC, 0)); em(8'hE0);
        for (int f = 0; f < 5; f++) probe(f);
        em(enc(K_LDI, RC, 0)); em(8'hF0);
        em(enc(K_ST, RA, RC));
        em(STOP);
        run(cyc);
        exp_a = (op == K_INC) ? va + 8'd1 : va - 8'd1;
        check(ram[8'hF0] == exp_a, "R10", "inc/dec result", ram[8'hF0], exp_a);
        for (int f = 0; f < 5; f++)
            check(ram[8'hE0 + f] == {7'b0, pre[8 + f]}, "R10", $sformatf("flag %0d kept", f),
                  ram[8'hE0 + f], pre[8 + f]);
    endtask

    task automatic halt_case(input logic [7:0] code);
        int cyc;
        hold_reset();
        em(enc(K_LDI, RA, 0)); em(8'h77);
        em(enc(K_LDI, RC, 0)); em(8'hA0);
        em(code);
        em(enc(K_ST, RA, RC));
        em(STOP);
        run(cyc);
        check(halted == 1'b1, "R11", "halted raised", halted, 1);
        repeat (12) @(negedge clk);
        check(halted == 1'b1, "R11", "halted held", halted, 1);
        check(ram[8'hA0] == 8'h00, "R11", "no store after stop", ram[8'hA0], 0);
        check(we_after_halt == 0, "R11", "writes while halted", we_after_halt, 0);
    endtask

    initial begin
        test_reset();
        test_timing();
        test_data();
        test_jumps();
        alu_case("R8", K_ADD, 8'h7F, 8'h01);
        alu_case("R8", K_ADD, 8'hFF, 8'h01);
        alu_case("R8", K_SUB, 8'h05, 8'h07);
        alu_case("R8", K_CMP, 8'h80, 8'h01);
        alu_case("R8", K_CMP, 8'h33, 8'h33);
        alu_case("R9", K_AND, 8'hF0, 8'h0F);
        alu_case("R9", K_OR,  8'hA5, 8'h0A);
        alu_case("R9", K_NOT, 8'h0F, 8'h00);
        alu_case("R9", K_RSH, 8'h80, 8'h03);
        alu_case("R9", K_RSH, 8'hFF, 8'h09);
        incdec_case(K_INC, 8'hFF);
        incdec_case(K_DEC, 8'h00);
        incdec_case(K_DEC, 8'h80);
        halt_case(8'h55);
        halt_case(8'h5E);
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        n_checks++;
        $display("FAIL watchdog (all): actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end
endmodule